// File: doc/BRIEF.md
# Multiplexed Byte-Wide Host Register Port

This block is the device-side end of a narrow parallel host bus. The host has one 8-bit byte lane that carries both register indices and data. It also drives an active-low chip select, active-low write and read strobes, and a select line that marks an index cycle. The block answers on an active-low ready line. Every register access takes two bus cycles. In the first, the host writes a register index with the select line high. In the second, the host reads or writes data with the select line low, and that data cycle goes to the latched index. The index stays latched, so the host may run several data cycles against one register without sending the index again.

The host strobes are asynchronous to the block clock, so they are synchronized first. The latched index is then decoded into a small register map. For indices that belong to the internal register bank, the block sends out a one-cycle write or read strobe. It holds ready deasserted until the bank acknowledges. The revision byte is answered locally. Indices outside the map are answered at once: writes have no effect and reads return zero. The byte lane is bidirectional. The block drives it through a separate output enable, which is raised only while chip select and read are both low. The pad cell itself sits outside the block.

Top module: `hbus_reg_port`

## Requirements
- R1: After a synchronous active-low reset, ready (`bus_rdy_n`) is high, the output enable `bus_doe` is low while no read is strobed, and neither `tgt_wr` nor `tgt_rd` pulses.
- R2: A write with chip select low and `bus_sel` high latches the full 8-bit byte as the register index. It raises no bank strobe and completes by driving `bus_rdy_n` low.
- R3: The latched index holds across any number of data cycles. A new index cycle is the only thing that replaces it.
- R4: A data write (`bus_sel` low) to a bank index pulses `tgt_wr` for exactly one cycle, with `tgt_idx` set to the low 4 bits of the index and `tgt_wdata` set to the host byte. `bus_rdy_n` stays high until `tgt_ack` arrives. Bank indices are 0x00, 0x01, 0x04–0x07, 0x08–0x0A, 0x0C and 0x0D.
- R5: A data read of a bank index pulses `tgt_rd` for exactly one cycle. The block captures `tgt_rdata` in the cycle `tgt_ack` is high and presents that byte on `bus_dout` when `bus_rdy_n` goes low.
- R6: A data read of index 0x0F returns the `REVISION` parameter (default 0x2B) and strobes no bank. A data write to 0x0F strobes nothing and does not change what later reads return.
- R7: For an index outside the map (0x02, 0x03, 0x0B, 0x0E and anything above 0x0F), a data write strobes nothing and a data read returns 0x00. Both complete without waiting for the bank.
- R8: `bus_doe` is high exactly while `bus_cs_n` and `bus_rd_n` are both low. At all other times it is low and the lane is released.
- R9: Once `bus_rdy_n` is low, it stays low, and no further access starts, until the host releases its strobe. After the release, `bus_rdy_n` returns high.
- R10: A read with `bus_sel` high returns the currently latched index.
- R11: While `bus_cs_n` is high, the write and read strobes have no effect: no bank strobe and no change of ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | Host chip select, active low |
| bus_sel | input | 1 | High: index cycle; low: data cycle |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_din | input | 8 | Byte lane as seen from the pad (host to block) |
| bus_dout | output | 8 | Byte driven toward the host on reads |
| bus_doe | output | 1 | Output enable for the byte-lane pad |
| bus_rdy_n | output | 1 | Ready to the host, active low |
| tgt_idx | output | 4 | Register index presented to the bank |
| tgt_wdata | output | 8 | Write byte presented to the bank |
| tgt_wr | output | 1 | One-cycle bank write strobe |
| tgt_rd | output | 1 | One-cycle bank read strobe |
| tgt_rdata | input | 8 | Bank read byte, valid with `tgt_ack` |
| tgt_ack | input | 1 | Bank completion, one cycle per strobe |

## Verification
The assertions take three things for granted. First, the host keeps `bus_sel` and the byte lane stable from the moment a strobe falls until ready comes back. Second, it never lowers write and read together. Third, the bank answers each strobe with exactly one `tgt_ack`, and never without a strobe. The stimulus follows these rules. Every access sets up the lane and select in the same step that lowers the strobe, and leaves them unchanged until it releases the strobe after ready is seen. The bank model acknowledges each strobe once, after a latency the test chooses, including long latencies that stretch the wait for ready.

// File: rtl/hbus_pkg.sv
// Shared types for the multiplexed host register port.
// Assumes: register map indices fit in the low four bits of the index byte.
package hbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } hb_state_t;

    typedef enum logic [1:0] {
        CL_NONE = 2'd0,
        CL_BANK = 2'd1,
        CL_REV  = 2'd2
    } hb_class_t;

    localparam logic [7:0] IX_IRQ_CTL  = 8'h00;
    localparam logic [7:0] IX_BUS_CTL2 = 8'h01;
    localparam logic [7:0] IX_SLOT_ALO = 8'h04;
    localparam logic [7:0] IX_SLOT_AHI = 8'h05;
    localparam logic [7:0] IX_SLOT_DAT = 8'h06;
    localparam logic [7:0] IX_BUS_CTL  = 8'h07;
    localparam logic [7:0] IX_FILT_ALO = 8'h08;
    localparam logic [7:0] IX_FILT_AHI = 8'h09;
    localparam logic [7:0] IX_FILT_DAT = 8'h0A;
    localparam logic [7:0] IX_CLKDIV_A = 8'h0C;
    localparam logic [7:0] IX_CLKDIV_B = 8'h0D;
    localparam logic [7:0] IX_REVISION = 8'h0F;

endpackage

// File: rtl/hbus_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous host pins.
// Assumes: each bit is treated independently; a bundle may settle over one
// extra cycle, which the controller tolerates because it only acts on a
// strobe that has been low for the whole synchronizer depth.
module hbus_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;

            // Shift the raw pin through the flop chain, reset to its idle level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
                else        chain <= {chain[STAGES-2:0], async_in[b]};
            end

            assign sync_out[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/hbus_decode.sv
// Classifies a latched index byte as a bank register, the local revision
// byte, or an unmapped index.
// Assumes: purely combinational; the index is held stable by the controller.
module hbus_decode
    import hbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] idx,
    output hb_class_t     cls
);

    // Map an index byte onto its access class.
    always_comb begin
        case (idx)
            IX_IRQ_CTL, IX_BUS_CTL2,
            IX_SLOT_ALO, IX_SLOT_AHI, IX_SLOT_DAT, IX_BUS_CTL,
            IX_FILT_ALO, IX_FILT_AHI, IX_FILT_DAT,
            IX_CLKDIV_A, IX_CLKDIV_B: cls = CL_BANK;
            IX_REVISION:              cls = CL_REV;
            default:                  cls = CL_NONE;
        endcase
    end

endmodule

// File: rtl/hbus_ctrl.sv
// Access sequencer: turns synchronized host strobes into index latching,
// bank strobes and local replies, and holds ready until the strobe is released.
// Assumes: host keeps sel and the byte lane stable while a strobe is low and
// never lowers write and read together; the bank acks each strobe once.
module hbus_ctrl
    import hbus_pkg::*;
#(
    parameter int          DW       = 8,
    parameter logic [DW-1:0] REVISION = 8'h2B
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_cs_n,
    input  logic          s_sel,
    input  logic          s_wr_n,
    input  logic          s_rd_n,
    input  logic [DW-1:0] din,
    input  hb_class_t     cls,
    input  logic          tgt_ack,
    input  logic [DW-1:0] tgt_rdata,
    output logic [DW-1:0] idx_q,
    output logic [DW-1:0] rdata_q,
    output logic [DW-1:0] wdata_q,
    output logic          tgt_wr,
    output logic          tgt_rd,
    output logic          rdy_n,
    output logic          acc_live
);

    hb_state_t state;
    logic      op_rd_q;
    logic      is_wr;
    logic      idx_load;

    assign acc_live = !s_cs_n && (!s_wr_n || !s_rd_n);
    assign is_wr    = !s_wr_n;
    assign idx_load = (state == ST_IDLE) && acc_live && s_sel && is_wr;
    assign rdy_n    = (state != ST_DONE);

    // Sequence one access: start, optional bank wait, then hold until release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx_q   <= '0;
            rdata_q <= '0;
            wdata_q <= '0;
            op_rd_q <= 1'b0;
            tgt_wr  <= 1'b0;
            tgt_rd  <= 1'b0;
        end else begin
            tgt_wr <= 1'b0;
            tgt_rd <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (acc_live) begin
                        op_rd_q <= !is_wr;
                        if (s_sel) begin
                            if (is_wr) idx_q   <= din;
                            else       rdata_q <= idx_q;
                            state <= ST_DONE;
                        end else begin
                            case (cls)
                                CL_BANK: begin
                                    tgt_wr  <= is_wr;
                                    tgt_rd  <= !is_wr;
                                    wdata_q <= din;
                                    state   <= ST_WAIT;
                                end
                                CL_REV: begin
                                    if (!is_wr) rdata_q <= REVISION;
                                    state <= ST_DONE;
                                end
                                default: begin
                                    if (!is_wr) rdata_q <= '0;
                                    state <= ST_DONE;
                                end
                            endcase
                        end
                    end
                end
                ST_WAIT: begin
                    if (tgt_ack) begin
                        if (op_rd_q) rdata_q <= tgt_rdata;
                        state <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (!acc_live) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr |=> !tgt_wr);

    // R5
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rd |=> !tgt_rd);

    // R3
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(idx_q) |-> $past(idx_load));

    // R9
    rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> acc_live);

    // R9
    rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_n) |-> !$past(acc_live));

    // R4
    wait_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_wr || tgt_rd) |-> rdy_n);

endmodule

// File: rtl/hbus_reg_port.sv
// Top of the multiplexed byte-wide host register port: synchronizes host
// strobes, decodes the latched index and drives the bank and the byte lane.
// Assumes: byte lane and select are stable while a strobe is low; the pad
// cell combining bus_dout/bus_doe/bus_din lives outside this block.
module hbus_reg_port
    import hbus_pkg::*;
#(
    parameter int            DW          = 8,
    parameter int            TIDX_W      = 4,
    parameter int            SYNC_STAGES = 2,
    parameter logic [DW-1:0] REVISION    = 8'h2B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_sel,
    input  logic              bus_wr_n,
    input  logic              bus_rd_n,
    input  logic [DW-1:0]     bus_din,
    output logic [DW-1:0]     bus_dout,
    output logic              bus_doe,
    output logic              bus_rdy_n,
    output logic [TIDX_W-1:0] tgt_idx,
    output logic [DW-1:0]     tgt_wdata,
    output logic              tgt_wr,
    output logic              tgt_rd,
    input  logic [DW-1:0]     tgt_rdata,
    input  logic              tgt_ack
);

    localparam int NCTL = 4;

    logic [NCTL-1:0] s_ctl;
    logic [DW-1:0]   idx_q;
    logic [DW-1:0]   rdata_q;
    logic            acc_live;
    hb_class_t       cls;

    hbus_sync #(
        .WIDTH   (NCTL),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1110)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bus_cs_n, bus_wr_n, bus_rd_n, bus_sel}),
        .sync_out (s_ctl)
    );

    hbus_decode #(.DW(DW)) u_dec (
        .idx (idx_q),
        .cls (cls)
    );

    hbus_ctrl #(.DW(DW), .REVISION(REVISION)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_cs_n    (s_ctl[3]),
        .s_sel     (s_ctl[0]),
        .s_wr_n    (s_ctl[2]),
        .s_rd_n    (s_ctl[1]),
        .din       (bus_din),
        .cls       (cls),
        .tgt_ack   (tgt_ack),
        .tgt_rdata (tgt_rdata),
        .idx_q     (idx_q),
        .rdata_q   (rdata_q),
        .wdata_q   (tgt_wdata),
        .tgt_wr    (tgt_wr),
        .tgt_rd    (tgt_rd),
        .rdy_n     (bus_rdy_n),
        .acc_live  (acc_live)
    );

    assign tgt_idx  = idx_q[TIDX_W-1:0];
    assign bus_dout = rdata_q;
    assign bus_doe  = !bus_cs_n && !bus_rd_n;

    // R7
    bank_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_wr || tgt_rd) |-> (cls == CL_BANK));

    // R11
    cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_wr || tgt_rd) |-> $past(acc_live));

    // R4
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tgt_wr && tgt_rd));

endmodule

// File: tb/hbus_reg_port_tb_top.sv
module hbus_reg_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs_n = 1'b1, bus_sel = 1'b0, bus_wr_n = 1'b1, bus_rd_n = 1'b1;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout;
    logic       bus_doe, bus_rdy_n;
    logic [3:0] tgt_idx;
    logic [7:0] tgt_wdata;
    logic       tgt_wr, tgt_rd;
    logic [7:0] tgt_rdata = 8'h00;
    logic       tgt_ack = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int bank_lat = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;

    logic [7:0] mem [16];
    logic       pend = 1'b0, pw = 1'b0;
    logic [3:0] pidx = 4'h0;
    logic [7:0] pdata = 8'h00;
    int         pcnt = 0;

    always #5 clk = ~clk;

    hbus_reg_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_sel(bus_sel),
        .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_rdy_n(bus_rdy_n),
        .tgt_idx(tgt_idx), .tgt_wdata(tgt_wdata), .tgt_wr(tgt_wr),
        .tgt_rd(tgt_rd), .tgt_rdata(tgt_rdata), .tgt_ack(tgt_ack)
    );

    initial begin
        for (int k = 0; k < 16; k++) mem[k] = 8'h00;
    end

    // Bank model: answers each strobe with one ack after bank_lat cycles.
    always @(posedge clk) begin
        tgt_ack <= 1'b0;
        if (tgt_wr) wr_cnt <= wr_cnt + 1;
        if (tgt_rd) rd_cnt <= rd_cnt + 1;
        if (tgt_wr || tgt_rd) begin
            pend  <= 1'b1;
            pw    <= tgt_wr;
            pidx  <= tgt_idx;
            pdata <= tgt_wdata;
            pcnt  <= bank_lat;
        end else if (pend) begin
            if (pcnt == 0) begin
                pend    <= 1'b0;
                tgt_ack <= 1'b1;
                if (pw) mem[pidx] <= pdata;
                else    tgt_rdata <= mem[pidx];
            end else begin
                pcnt <= pcnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One full host access: strobe, wait for ready, capture, release, wait idle.
    task automatic access(input bit sel, input bit rd, input logic [7:0] d,
                          output logic [7:0] got, output int waited);
        bit ok;
        @(negedge clk);
        bus_sel  = sel;
        bus_din  = d;
        bus_cs_n = 1'b0;
        if (rd) bus_rd_n = 1'b0;
        else    bus_wr_n = 1'b0;
        waited = 0;
        ok = 1'b0;
        for (int t = 0; t < 300; t++) begin
            @(negedge clk);
            waited++;
            if (!bus_rdy_n) begin ok = 1'b1; break; end
        end
        chk(ok, "R9 ready timeout", 0, 1);
        got = bus_dout;
        if (rd) chk(bus_doe == 1'b1, "R8 drive on read", bus_doe, 1);
        else    chk(bus_doe == 1'b0, "R8 no drive on write", bus_doe, 0);
        bus_cs_n = 1'b1; bus_wr_n = 1'b1; bus_rd_n = 1'b1;
        ok = 1'b0;
        for (int t = 0; t < 50; t++) begin
            @(negedge clk);
            if (bus_rdy_n) begin ok = 1'b1; break; end
        end
        chk(ok, "R9 ready release", 0, 1);
        @(negedge clk);
    endtask

    // {sel, rd, byte, expected read}
    localparam logic [17:0] VEC [0:16] = '{
        {1'b1, 1'b0, 8'h04, 8'h00},
        {1'b0, 1'b0, 8'h5A, 8'h00},
        {1'b1, 1'b0, 8'h06, 8'h00},
        {1'b0, 1'b0, 8'hC3, 8'h00},
        {1'b1, 1'b0, 8'h04, 8'h00},
        {1'b0, 1'b1, 8'h00, 8'h5A},
        {1'b0, 1'b1, 8'h00, 8'h5A},
        {1'b1, 1'b1, 8'h00, 8'h04},
        {1'b1, 1'b0, 8'h0F, 8'h00},
        {1'b0, 1'b1, 8'h00, 8'h2B},
        {1'b0, 1'b0, 8'h77, 8'h00},
        {1'b0, 1'b1, 8'h00, 8'h2B},
        {1'b1, 1'b0, 8'h03, 8'h00},
        {1'b0, 1'b0, 8'h99, 8'h00},
        {1'b0, 1'b1, 8'h00, 8'h00},
        {1'b1, 1'b0, 8'h06, 8'h00},
        {1'b0, 1'b1, 8'h00, 8'hC3}
    };

    initial begin
        repeat (400000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] got;
        int         waited;
        int         w0, r0;
        bit         stay;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(bus_rdy_n == 1'b1, "R1 ready idle", bus_rdy_n, 1);
        chk(bus_doe == 1'b0, "R1 lane released", bus_doe, 0);
        chk(wr_cnt == 0 && rd_cnt == 0, "R1 no strobes", wr_cnt + rd_cnt, 0);

        // Vector walk: R2/R3/R5/R6/R7/R10
        for (int i = 0; i < 17; i++) begin
            access(VEC[i][17], VEC[i][16], VEC[i][15:8], got, waited);
            if (VEC[i][16])
                chk(got == VEC[i][7:0], "R3/R5/R6/R7/R10 vector read", got, VEC[i][7:0]);
        end
        chk(mem[4] == 8'h5A && mem[6] == 8'hC3, "R4 bank contents", {mem[4], mem[6]}, 16'h5AC3);
        chk(wr_cnt == 2, "R6/R7 writes to 0x0F/0x03 strobe nothing", wr_cnt, 2);
        chk(rd_cnt == 3, "R6/R7 local reads strobe nothing", rd_cnt, 3);
        chk(mem[3] == 8'h00 && mem[15] == 8'h00, "R6/R7 bank untouched", {mem[3], mem[15]}, 0);

        // R2 index write makes no strobe
        w0 = wr_cnt; r0 = rd_cnt;
        access(1'b1, 1'b0, 8'h08, got, waited);
        chk(wr_cnt == w0 && rd_cnt == r0, "R2 index cycle no strobe", wr_cnt + rd_cnt, w0 + r0);

        // R4 long bank latency holds ready off until ack
        bank_lat = 15;
        access(1'b0, 1'b0, 8'h11, got, waited);
        chk(waited > 15, "R4 ready waits for ack", waited, 16);
        chk(mem[8] == 8'h11 && wr_cnt == w0 + 1, "R4 single bank write", mem[8], 8'h11);
        access(1'b0, 1'b1, 8'h00, got, waited);
        chk(got == 8'h11, "R5 read after latency", got, 8'h11);
        bank_lat = 0;

        // R7 index above the map
        w0 = wr_cnt;
        access(1'b1, 1'b0, 8'h14, got, waited);
        access(1'b0, 1'b0, 8'hEE, got, waited);
        access(1'b0, 1'b1, 8'h00, got, waited);
        chk(got == 8'h00, "R7 high index reads zero", got, 0);
        chk(wr_cnt == w0 && mem[4] == 8'h5A, "R7 high index write ignored", mem[4], 8'h5A);

        // R10 index read returns full latched byte
        access(1'b1, 1'b1, 8'h00, got, waited);
        chk(got == 8'h14, "R10 index readback", got, 8'h14);

        // R11 strobes with chip select high
        w0 = wr_cnt; r0 = rd_cnt;
        @(negedge clk);
        bus_sel = 1'b0; bus_din = 8'h55; bus_wr_n = 1'b0;
        stay = 1'b1;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (!bus_rdy_n) stay = 1'b0;
        end
        chk(stay, "R11 ready untouched", 0, 1);
        chk(wr_cnt == w0 && rd_cnt == r0, "R11 no strobe", wr_cnt + rd_cnt, w0 + r0);
        bus_rd_n = 1'b0; bus_wr_n = 1'b1;
        @(negedge clk);
        chk(bus_doe == 1'b0, "R8 no drive without cs", bus_doe, 0);
        bus_rd_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9 held strobe keeps ready low with no new access
        access(1'b1, 1'b0, 8'h06, got, waited);
        r0 = rd_cnt;
        @(negedge clk);
        bus_sel = 1'b0; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (!bus_rdy_n) break;
        end
        stay = 1'b1;
        for (int t = 0; t < 12; t++) begin
            @(negedge clk);
            if (bus_rdy_n) stay = 1'b0;
        end
        chk(stay, "R9 ready held while strobed", 0, 1);
        chk(rd_cnt == r0 + 1, "R9 one strobe per access", rd_cnt, r0 + 1);
        chk(bus_dout == 8'hC3, "R5 held read data", bus_dout, 8'hC3);
        bus_cs_n = 1'b1; bus_rd_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(bus_rdy_n == 1'b1, "R9 ready back high", bus_rdy_n, 1);
        chk(bus_doe == 1'b0, "R8 lane released after read", bus_doe, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule